// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit turns a decoded load request into the value that belongs in a destination register. Each request carries a 3-bit mode selector, a 16-bit constant field and a base register value. The unit also sees the current program counter. From these it forms an effective address and reads a single-port synchronous data memory zero, one or two times. It then returns the fetched value together with a one-cycle done pulse.

Six modes are supported. Immediate mode uses the constant itself. Direct, register-indirect, indexed and PC-relative modes each need one memory read. Memory-indirect mode reads a pointer first and then the data that the pointer selects. The unit handles one request at a time, and a busy output tells the issuing stage when a request would be dropped.

Top module: `opfetch_unit`

## Requirements
- R1: Mode code 0 (immediate) returns the constant field, zero-extended, with no memory read. Done is high in the cycle right after the cycle in which the request is accepted.
- R2: Mode code 1 (direct) performs one read at the address given by the constant and returns the word read.
- R3: Mode code 2 (register indirect) performs one read at the address given by the base value and returns the word read.
- R4: Mode code 3 (indexed) performs one read at (base + constant) mod 2^16 and returns the word read.
- R5: Mode code 4 (relative) performs one read at (pc + constant) mod 2^16 and returns the word read.
- R6: Mode code 5 (memory indirect) performs two reads. The first is at the constant. The second is at the low 16 bits of the word returned by the first. The result is the word returned by the second read.
- R7: Mode codes 6 and 7 make no memory read. They return zero with the illegal flag high in the done cycle, in the cycle after acceptance. The illegal flag is low whenever done is low, and in every legal done cycle.
- R8: The memory returns data in the cycle after the one in which the read strobe is high. The strobe is never high for two cycles in a row. Counting the request cycle as cycle 0, a single-read mode strobes in cycle 1 and raises done in cycle 3. Memory-indirect mode strobes in cycles 1 and 3 and raises done in cycle 5.
- R9: Busy is high in every cycle from the one after acceptance up to, but not including, the done cycle. It is low in the done cycle. A request presented while busy is high has no effect on reads, result or timing.
- R10: While reset is held, busy, done, the illegal flag and the read strobe are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_mode | input | 3 | Addressing mode code |
| req_const | input | 16 | Constant field |
| req_base | input | 16 | Base register value |
| pc | input | 16 | Current program counter |
| busy | output | 1 | Request in progress; new requests are dropped |
| done | output | 1 | One-cycle pulse: result valid |
| illegal | output | 1 | Mode code was not defined (valid with done) |
| result | output | 16 | Fetched operand, held until the next done |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, one cycle after the strobe |

## Verification
The hardest case to reach from the ports is memory-indirect mode under pressure. In this case the second address comes from data the memory itself returned, and the issuing side keeps presenting new requests while the two reads are in flight. The bench's memory model returns a word that is a scrambling function of its address, so every pointer chases to a distinct and predictable data word. A marker value is driven when no read is pending, which exposes sampling in the wrong cycle. During every busy window the bench drives random junk requests, and it aims directed cases at 16-bit wrap-around in the indexed and relative sums.

// File: rtl/opfetch_pkg.sv
// Package: shared mode codes and sequencer state type for the operand fetch unit.
// Assumes: mode field is 3 bits wide; codes 6 and 7 are undefined.
package opfetch_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] AM_IMM  = 3'd0;
    localparam logic [MODE_W-1:0] AM_DIR  = 3'd1;
    localparam logic [MODE_W-1:0] AM_RIND = 3'd2;
    localparam logic [MODE_W-1:0] AM_IDX  = 3'd3;
    localparam logic [MODE_W-1:0] AM_REL  = 3'd4;
    localparam logic [MODE_W-1:0] AM_MIND = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_A  = 3'd1,
        ST_CAP_A = 3'd2,
        ST_RD_B  = 3'd3,
        ST_CAP_B = 3'd4
    } fetch_state_e;

endpackage

// File: rtl/opfetch_ea.sv
// Module: opfetch_ea
// Decodes the mode code and forms the first effective address, combinationally.
// Assumes: constant, base and pc are all AW bits; sums wrap modulo 2^AW.
module opfetch_ea
    import opfetch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     cval,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     pc,
    output logic [AW-1:0]     ea,
    output logic              is_imm,
    output logic              is_ill,
    output logic              two_step,
    output logic [DW-1:0]     imm_val
);

    logic [AW-1:0] sum_base;
    logic [AW-1:0] sum_pc;

    // Wrapping adders for the indexed and relative modes.
    always_comb begin
        sum_base = base + cval;
        sum_pc   = pc + cval;
    end

    // Mode decode and first-address selection.
    always_comb begin
        ea       = cval;
        is_imm   = 1'b0;
        is_ill   = 1'b0;
        two_step = 1'b0;
        unique case (mode)
            AM_IMM:  is_imm = 1'b1;
            AM_DIR:  ea = cval;
            AM_RIND: ea = base;
            AM_IDX:  ea = sum_base;
            AM_REL:  ea = sum_pc;
            AM_MIND: begin
                ea       = cval;
                two_step = 1'b1;
            end
            default: is_ill = 1'b1;
        endcase
    end

    // Zero-extension of the constant for the immediate result.
    always_comb begin
        imm_val          = '0;
        imm_val[AW-1:0]  = cval;
    end

endmodule

// File: rtl/opfetch_seq.sv
// Module: opfetch_seq
// Sequences zero, one or two memory reads per request and produces the
// result with a done pulse. Memory data is taken one cycle after the strobe.
// Assumes: DW >= AW so a read word can serve as a pointer.
module opfetch_seq
    import opfetch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] ea,
    input  logic          is_imm,
    input  logic          is_ill,
    input  logic          two_step,
    input  logic [DW-1:0] imm_val,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic [DW-1:0] result,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr
);

    fetch_state_e  state_q;
    logic [AW-1:0] addr_q;
    logic          second_q;
    logic [DW-1:0] result_q;
    logic          done_q;
    logic          ill_q;
    logic          accept;

    // A request is taken only while idle.
    always_comb accept = req_valid && (state_q == ST_IDLE);

    // Main sequencer: address latch, read phases, result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            second_q <= 1'b0;
            result_q <= '0;
            done_q   <= 1'b0;
            ill_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (is_ill) begin
                            result_q <= '0;
                            ill_q    <= 1'b1;
                            done_q   <= 1'b1;
                        end else if (is_imm) begin
                            result_q <= imm_val;
                            done_q   <= 1'b1;
                        end else begin
                            addr_q   <= ea;
                            second_q <= two_step;
                            state_q  <= ST_RD_A;
                        end
                    end
                end
                ST_RD_A:  state_q <= ST_CAP_A;
                ST_CAP_A: begin
                    if (second_q) begin
                        addr_q  <= mem_rdata[AW-1:0];
                        state_q <= ST_RD_B;
                    end else begin
                        result_q <= mem_rdata;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_RD_B:  state_q <= ST_CAP_B;
                ST_CAP_B: begin
                    result_q <= mem_rdata;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive from sequencer state.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        mem_rd   = (state_q == ST_RD_A) || (state_q == ST_RD_B);
        mem_addr = addr_q;
        done     = done_q;
        illegal  = ill_q;
        result   = result_q;
    end

    // Immediate requests finish next cycle without touching memory.
    assert_imm_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_imm) |=> (done && !mem_rd && !illegal));

    // Undefined codes report illegal with a zero result.
    assert_ill_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && result == '0 && !mem_rd));

    // The read strobe never stays high for two cycles.
    assert_strobe_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // Read data is consumed only one cycle after a strobe.
    assert_done_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && $past(busy)) |-> $past(mem_rd, 2));

    // No strobe and no done while a request is in flight but outside its phases.
    assert_busy_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // The read address stays put while the strobe is high.
    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && mem_rd) |=> $stable(mem_addr));

endmodule

// File: rtl/opfetch_unit.sv
// Module: opfetch_unit (top)
// Operand fetch for six addressing modes against a single-port synchronous
// memory with one-cycle read latency.
// Assumes: the issuing side holds no request while busy is high, or accepts
// that such requests are dropped.
module opfetch_unit
    import opfetch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [AW-1:0]     req_const,
    input  logic [AW-1:0]     req_base,
    input  logic [AW-1:0]     pc,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DW-1:0]     result,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata
);

    logic [AW-1:0] ea;
    logic          is_imm;
    logic          is_ill;
    logic          two_step;
    logic [DW-1:0] imm_val;

    opfetch_ea #(.AW(AW), .DW(DW)) u_ea (
        .mode     (req_mode),
        .cval     (req_const),
        .base     (req_base),
        .pc       (pc),
        .ea       (ea),
        .is_imm   (is_imm),
        .is_ill   (is_ill),
        .two_step (two_step),
        .imm_val  (imm_val)
    );

    opfetch_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ea        (ea),
        .is_imm    (is_imm),
        .is_ill    (is_ill),
        .two_step  (two_step),
        .imm_val   (imm_val),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .result    (result),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr)
    );

    // Reset leaves every output quiet.
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_rd && !illegal));

endmodule

// File: tb/opfetch_unit_tb.sv
module opfetch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [15:0] req_const = '0;
    logic [15:0] req_base = '0;
    logic [15:0] pc = '0;
    logic        busy, done, illegal, mem_rd;
    logic [15:0] result, mem_addr;
    logic [15:0] mem_rdata = 16'hDEAD;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    opfetch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_const(req_const), .req_base(req_base), .pc(pc), .busy(busy),
        .done(done), .illegal(illegal), .result(result), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    // Memory model: scrambled content, marker value when no read is pending.
    function automatic logic [15:0] memf(input logic [15:0] a);
        logic [31:0] p;
        p = {16'h0, a} * 32'd40503;
        return p[15:0] ^ 16'h3C3C;
    endfunction

    always @(posedge clk) mem_rdata <= mem_rd ? memf(mem_addr) : 16'hDEAD;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string mtag(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Entered and left at a negative edge.
    task automatic run_req(input logic [2:0] m, input logic [15:0] c, input logic [15:0] b,
                           input logic [15:0] p, input bit junk);
        logic [15:0] exp_res;
        logic [15:0] exp_a [2];
        int exp_n;
        int exp_lat;
        logic [15:0] got_a [4];
        int got_n = 0;
        int lat = 1;
        bit busy_ok = 1'b1;
        exp_n = 0; exp_lat = 1; exp_res = 16'h0;
        exp_a[0] = 16'h0; exp_a[1] = 16'h0;
        case (m)
            3'd0: exp_res = c;
            3'd1: begin exp_a[0] = c;     exp_n = 1; end
            3'd2: begin exp_a[0] = b;     exp_n = 1; end
            3'd3: begin exp_a[0] = b + c; exp_n = 1; end
            3'd4: begin exp_a[0] = p + c; exp_n = 1; end
            3'd5: begin exp_a[0] = c; exp_a[1] = memf(c); exp_n = 2; end
            default: exp_res = 16'h0;
        endcase
        if (exp_n == 1) begin exp_res = memf(exp_a[0]); exp_lat = 3; end
        if (exp_n == 2) begin exp_res = memf(exp_a[1]); exp_lat = 5; end

        req_mode = m; req_const = c; req_base = b; pc = p; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        while (!done && lat < 12) begin
            if (!busy) busy_ok = 1'b0;
            if (mem_rd && got_n < 4) begin got_a[got_n] = mem_addr; got_n++; end
            req_valid = junk ? 1'($urandom_range(0, 1)) : 1'b0;
            req_mode  = 3'($urandom);
            req_const = 16'($urandom);
            req_base  = 16'($urandom);
            pc        = 16'($urandom);
            @(negedge clk);
            lat++;
        end
        if (mem_rd) got_n++;
        req_valid = 1'b0;
        chk(busy_ok && !busy, "R9 busy window", {31'h0, busy_ok}, 32'h1);
        chk(lat == exp_lat, "R8 done latency", lat, exp_lat);
        chk(result == exp_res, {mtag(m), " result"}, result, exp_res);
        chk(illegal == (m > 3'd5), {mtag(m), " illegal flag"}, illegal, m > 3'd5);
        chk(got_n == exp_n, {mtag(m), " read count"}, got_n, exp_n);
        for (int i = 0; i < exp_n; i++)
            if (i < got_n)
                chk(got_a[i] == exp_a[i], {mtag(m), " read address"}, got_a[i], exp_a[i]);
    endtask

    initial begin
        void'($urandom(32'd20240613));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs quiet under reset
        chk(!busy && !done && !illegal && !mem_rd && result == 16'h0, "R10 reset state",
            {busy, done, illegal, mem_rd, result}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        run_req(3'd0, 16'hBEEF, 16'h0, 16'h0, 1'b0);      // R1
        run_req(3'd0, 16'h1234, 16'h0, 16'h0, 1'b0);      // R1 back to back
        run_req(3'd1, 16'h0040, 16'h0, 16'h0, 1'b0);      // R2
        run_req(3'd2, 16'h0, 16'hA5A5, 16'h0, 1'b0);      // R3
        run_req(3'd3, 16'h0100, 16'hFF80, 16'h0, 1'b0);   // R4 wrap
        run_req(3'd4, 16'h0020, 16'h0, 16'hFFF0, 1'b0);   // R5 wrap
        run_req(3'd5, 16'h0007, 16'h0, 16'h0, 1'b1);      // R6 with junk while busy
        run_req(3'd6, 16'h5555, 16'h0, 16'h0, 1'b0);      // R7
        run_req(3'd7, 16'hFFFF, 16'h0, 16'h0, 1'b0);      // R7

        // Constrained random mix, junk requests during busy windows (R9)
        for (int k = 0; k < 300; k++) begin
            run_req(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
                    16'($urandom), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        finish_run();
    end

endmodule